// File: doc/BRIEF.md
# Branch and Jump Next-PC Unit

This unit resolves control flow for a 32-bit classic RISC core whose branches and jumps have one delay slot. Each cycle it receives an instruction word, the address it was fetched from and the values of its two source registers. From these it decides whether control moves. It produces the address the fetch stage should use next. For instructions that save a return address, it also provides the register-file write: an enable, a destination index and the value.

Branch targets are formed from the delay-slot address, which is the instruction address plus 4. A return address points past the delay slot. Every result is captured in a register stage, so the outputs describe the instruction that was presented one clock earlier. Register reads, pipeline flushes and fetch itself are outside this unit.

Top module: `npc_unit`

## Requirements
- R1: For any word that is not one of the branch or jump encodings below, and for any branch whose condition fails, `next_pc_o` equals the instruction address plus 4 and `taken_o` is 0. For any word that is not one of the branch or jump encodings below, `link_we_o`, `link_idx_o`, `link_val_o` and `addr_err_o` are also 0.
- R2: Opcode bits [31:26] = 000100 is taken when the two register values are equal, and 000101 is taken when they differ. When taken, the target is (address + 4) + (sign-extended bits [15:0] shifted left by 2), computed modulo 2^32.
- R3: Opcode 000110 is taken when rs ≤ 0, and opcode 000111 is taken when rs > 0. Both compares are signed. Bits [20:16] have no effect on either opcode. The target is formed as in R2.
- R4: Opcode 000001 selects its operation from bits [20:16]. The code 00000 branches if rs < 0, 00001 if rs ≥ 0, 10000 if rs < 0 with link, and 10001 if rs ≥ 0 with link. Every other code is not a branch. The target is formed as in R2.
- R5: Opcode 000010 (jump) and opcode 000011 (jump with link) are always taken. The target is {bits [31:28] of (address + 4), bits [25:0], 2'b00}.
- R6: Under opcode 000000, function bits [5:0] = 001000 (register jump) and 001001 (register jump with link) are always taken, and the target is the rs value. Every other function code is not a branch.
- R7: The link forms set `link_we_o` whether or not the branch is taken, and `link_val_o` is then the address + 8. `link_idx_o` is 31 for opcode 000011 and for the two linking codes of opcode 000001, and it is bits [15:11] for the register jump with link. When `link_we_o` is 0, `link_idx_o` and `link_val_o` are 0.
- R8: `addr_err_o` is 1 exactly when a register jump (with or without link) targets a value whose bits [1:0] are not 00. The jump is still reported as taken to that value.
- R9: All outputs are registered and change on the rising clock edge after the inputs are applied. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_i | input | 32 | Instruction word |
| pc_i | input | 32 | Address of the instruction |
| rs_val_i | input | 32 | Value of the rs source register |
| rt_val_i | input | 32 | Value of the rt source register |
| taken_o | output | 1 | Control transfer taken |
| next_pc_o | output | 32 | Next fetch address |
| link_we_o | output | 1 | Return-address write enable |
| link_idx_o | output | 5 | Return-address destination register |
| link_val_o | output | 32 | Return address |
| addr_err_o | output | 1 | Misaligned register-jump target |

## Verification
The bench sweeps signed boundary values through every compare. These include zero, ±1, the most positive value and the most negative value. A design that compared unsigned, or that tested zero with the wrong inequality, would take the wrong path at 0 or at the sign boundary. Region jumps are placed so that the delay slot crosses into a new 256 MB region. A unit that took the upper bits from the branch address itself would then land 256 MB short. The bench also walks every opcode, every function code and every register-immediate selector code. This exposes decoders that treat stray codes as branches, or that drop the link on untaken branch-and-link forms.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int INSN_W    = 32;
  localparam int RIDX_W    = 5;
  localparam int LINK_REG  = 31;

  localparam logic [5:0] OP_SPECIAL = 6'b000000;
  localparam logic [5:0] OP_REGIMM  = 6'b000001;
  localparam logic [5:0] OP_JMP     = 6'b000010;
  localparam logic [5:0] OP_JMPL    = 6'b000011;
  localparam logic [5:0] OP_BREQ    = 6'b000100;
  localparam logic [5:0] OP_BRNE    = 6'b000101;
  localparam logic [5:0] OP_BRLEZ   = 6'b000110;
  localparam logic [5:0] OP_BRGTZ   = 6'b000111;

  localparam logic [5:0] FN_RJMP    = 6'b001000;
  localparam logic [5:0] FN_RJMPL   = 6'b001001;

  localparam logic [4:0] RI_LTZ     = 5'b00000;
  localparam logic [4:0] RI_GEZ     = 5'b00001;
  localparam logic [4:0] RI_LTZ_L   = 5'b10000;
  localparam logic [4:0] RI_GEZ_L   = 5'b10001;

  typedef enum logic [3:0] {
    BK_NONE, BK_EQ, BK_NE, BK_LEZ, BK_GTZ, BK_LTZ, BK_GEZ, BK_REGION, BK_REG
  } bkind_e;

  typedef struct packed {
    bkind_e            kind;
    logic              link;
    logic [RIDX_W-1:0] link_idx;
  } bdec_t;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [INSN_W-1:0] instr_i,
  output bdec_t             dec_o
);
  logic [5:0]        opc;
  logic [5:0]        fn;
  logic [RIDX_W-1:0] sel;
  logic [RIDX_W-1:0] rd;

  assign opc = instr_i[31:26];
  assign fn  = instr_i[5:0];
  assign sel = instr_i[20:16];
  assign rd  = instr_i[15:11];

  always_comb begin
    dec_o.kind     = BK_NONE;
    dec_o.link     = 1'b0;
    dec_o.link_idx = '0;
    unique case (opc)
      OP_BREQ:  dec_o.kind = BK_EQ;
      OP_BRNE:  dec_o.kind = BK_NE;
      OP_BRLEZ: dec_o.kind = BK_LEZ;
      OP_BRGTZ: dec_o.kind = BK_GTZ;
      OP_JMP:   dec_o.kind = BK_REGION;
      OP_JMPL: begin
        dec_o.kind     = BK_REGION;
        dec_o.link     = 1'b1;
        dec_o.link_idx = RIDX_W'(LINK_REG);
      end
      OP_REGIMM: begin
        unique case (sel)
          RI_LTZ:   dec_o.kind = BK_LTZ;
          RI_GEZ:   dec_o.kind = BK_GEZ;
          RI_LTZ_L: begin
            dec_o.kind     = BK_LTZ;
            dec_o.link     = 1'b1;
            dec_o.link_idx = RIDX_W'(LINK_REG);
          end
          RI_GEZ_L: begin
            dec_o.kind     = BK_GEZ;
            dec_o.link     = 1'b1;
            dec_o.link_idx = RIDX_W'(LINK_REG);
          end
          default: dec_o.kind = BK_NONE;
        endcase
      end
      OP_SPECIAL: begin
        if (fn == FN_RJMP) begin
          dec_o.kind = BK_REG;
        end else if (fn == FN_RJMPL) begin
          dec_o.kind     = BK_REG;
          dec_o.link     = 1'b1;
          dec_o.link_idx = rd;
        end
      end
      default: dec_o.kind = BK_NONE;
    endcase
  end
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  bkind_e            kind_i,
  input  logic [XLEN-1:0]   rs_i,
  input  logic [XLEN-1:0]   rt_i,
  output logic              take_o
);
  logic neg;
  logic zero;

  assign neg  = rs_i[XLEN-1];
  assign zero = (rs_i == '0);

  always_comb begin
    unique case (kind_i)
      BK_EQ:     take_o = (rs_i == rt_i);
      BK_NE:     take_o = (rs_i != rt_i);
      BK_LEZ:    take_o = neg | zero;
      BK_GTZ:    take_o = ~neg & ~zero;
      BK_LTZ:    take_o = neg;
      BK_GEZ:    take_o = ~neg;
      BK_REGION: take_o = 1'b1;
      BK_REG:    take_o = 1'b1;
      default:   take_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pc_i,
  input  logic [INSN_W-1:0] instr_i,
  input  bkind_e            kind_i,
  input  logic [XLEN-1:0]   rs_i,
  output logic [XLEN-1:0]   slot_pc_o,
  output logic [XLEN-1:0]   target_o,
  output logic              misal_o
);
  localparam int IDX_W  = 26;
  localparam int LOW_W  = IDX_W + 2;
  localparam int OFF_W  = 16;
  localparam int SEXT_W = XLEN - OFF_W - 2;

  logic [XLEN-1:0] off_x;
  logic [XLEN-1:0] rel_t;
  logic [XLEN-1:0] reg_t;

  assign slot_pc_o = pc_i + XLEN'(4);
  assign off_x     = {{SEXT_W{instr_i[OFF_W-1]}}, instr_i[OFF_W-1:0], 2'b00};
  assign rel_t     = slot_pc_o + off_x;
  assign reg_t     = {slot_pc_o[XLEN-1:LOW_W], instr_i[IDX_W-1:0], 2'b00};

  always_comb begin
    unique case (kind_i)
      BK_REGION: target_o = reg_t;
      BK_REG:    target_o = rs_i;
      default:   target_o = rel_t;
    endcase
  end

  assign misal_o = (kind_i == BK_REG) && (rs_i[1:0] != 2'b00);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       instr_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs_val_i,
  input  logic [XLEN-1:0]   rt_val_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o,
  output logic              link_we_o,
  output logic [4:0]        link_idx_o,
  output logic [XLEN-1:0]   link_val_o,
  output logic              addr_err_o
);
  typedef struct packed {
    logic              taken;
    logic [XLEN-1:0]   next_pc;
    logic              link_we;
    logic [RIDX_W-1:0] link_idx;
    logic [XLEN-1:0]   link_val;
    logic              addr_err;
  } out_t;

  bdec_t           dec;
  logic            take;
  logic [XLEN-1:0] slot_pc;
  logic [XLEN-1:0] target;
  logic            misal;
  out_t            out_d;
  out_t            out_q;

  npc_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  npc_cond #(.XLEN(XLEN)) u_cond (
    .kind_i (dec.kind),
    .rs_i   (rs_val_i),
    .rt_i   (rt_val_i),
    .take_o (take)
  );

  npc_target #(.XLEN(XLEN)) u_tgt (
    .pc_i      (pc_i),
    .instr_i   (instr_i),
    .kind_i    (dec.kind),
    .rs_i      (rs_val_i),
    .slot_pc_o (slot_pc),
    .target_o  (target),
    .misal_o   (misal)
  );

  always_comb begin
    out_d.taken    = take;
    out_d.next_pc  = take ? target : slot_pc;
    out_d.link_we  = dec.link;
    out_d.link_idx = dec.link ? dec.link_idx : '0;
    out_d.link_val = dec.link ? (pc_i + XLEN'(8)) : '0;
    out_d.addr_err = misal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else begin
      out_q <= out_d;
    end
  end

  assign taken_o    = out_q.taken;
  assign next_pc_o  = out_q.next_pc;
  assign link_we_o  = out_q.link_we;
  assign link_idx_o = out_q.link_idx;
  assign link_val_o = out_q.link_val;
  assign addr_err_o = out_q.addr_err;

  p_fallthru_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (taken_o || next_pc_o == $past(pc_i) + XLEN'(4)));

  p_nolink_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !link_we_o |-> (link_idx_o == '0 && link_val_o == '0));

  p_eq_take_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (dec.kind == BK_EQ) |=> (taken_o == $past(rs_val_i == rt_val_i)));

  p_link_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dec.link |=> link_we_o);

  p_link_val_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (!link_we_o || link_val_o == $past(pc_i) + XLEN'(8)));

  p_err_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    addr_err_o |-> (taken_o && next_pc_o[1:0] != 2'b00));
endmodule

// File: tb/npc_unit_tb.sv
`timescale 1ns/100ps
module npc_unit_tb;
  logic        clk;
  logic        rst_n;
  logic [31:0] instr;
  logic [31:0] pc;
  logic [31:0] rs_v;
  logic [31:0] rt_v;
  logic        taken;
  logic [31:0] next_pc;
  logic        link_we;
  logic [4:0]  link_idx;
  logic [31:0] link_val;
  logic        addr_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [31:0] vals [8] = '{32'h0, 32'h1, 32'hFFFF_FFFF, 32'h7FFF_FFFF,
                            32'h8000_0000, 32'h5, 32'hFFFF_FFFB, 32'h1234_5678};

  npc_unit u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .instr_i    (instr),
    .pc_i       (pc),
    .rs_val_i   (rs_v),
    .rt_val_i   (rt_v),
    .taken_o    (taken),
    .next_pc_o  (next_pc),
    .link_we_o  (link_we),
    .link_idx_o (link_idx),
    .link_val_o (link_val),
    .addr_err_o (addr_err)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] itype(logic [5:0] op, logic [4:0] rsf, logic [4:0] rtf, logic [15:0] imm);
    return {op, rsf, rtf, imm};
  endfunction

  function automatic logic [31:0] rtype(logic [5:0] fn, logic [4:0] rsf, logic [4:0] rd);
    return {6'b000000, rsf, 5'd0, rd, 5'd0, fn};
  endfunction

  task automatic model(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] p, output logic tk, output logic [31:0] np,
                       output logic lw, output logic [4:0] li, output logic [31:0] lv,
                       output logic er);
    logic [31:0] p4, brt, tgt;
    logic [5:0]  op;
    op  = ins[31:26];
    p4  = p + 32'd4;
    brt = p4 + {{14{ins[15]}}, ins[15:0], 2'b00};
    tk = 0; tgt = brt; lw = 0; li = 0; er = 0;
    case (op)
      6'd4: tk = (a == b);
      6'd5: tk = (a != b);
      6'd6: tk = ($signed(a) <= 0);
      6'd7: tk = ($signed(a) > 0);
      6'd1: begin
        case (ins[20:16])
          5'd0:  tk = $signed(a) < 0;
          5'd1:  tk = $signed(a) >= 0;
          5'd16: begin tk = $signed(a) < 0;  lw = 1; li = 31; end
          5'd17: begin tk = $signed(a) >= 0; lw = 1; li = 31; end
          default: ;
        endcase
      end
      6'd2: begin tk = 1; tgt = {p4[31:28], ins[25:0], 2'b00}; end
      6'd3: begin tk = 1; tgt = {p4[31:28], ins[25:0], 2'b00}; lw = 1; li = 31; end
      6'd0: begin
        if (ins[5:0] == 6'd8 || ins[5:0] == 6'd9) begin
          tk = 1; tgt = a; er = (a[1:0] != 0);
          if (ins[5:0] == 6'd9) begin lw = 1; li = ins[15:11]; end
        end
      end
      default: ;
    endcase
    np = tk ? tgt : p4;
    lv = lw ? p + 32'd8 : 32'd0;
  endtask

  task automatic run(string tag, logic [31:0] ins, logic [31:0] p, logic [31:0] a, logic [31:0] b);
    logic tk, lw, er;
    logic [31:0] np, lv;
    logic [4:0] li;
    instr = ins; pc = p; rs_v = a; rt_v = b;
    model(ins, a, b, p, tk, np, lw, li, lv, er);
    @(negedge clk);
    chk(tag, "taken",    {31'd0, taken},    {31'd0, tk});
    chk(tag, "next_pc",  next_pc,           np);
    chk(tag, "link_we",  {31'd0, link_we},  {31'd0, lw});
    chk(tag, "link_idx", {27'd0, link_idx}, {27'd0, li});
    chk(tag, "link_val", link_val,          lv);
    chk(tag, "addr_err", {31'd0, addr_err}, {31'd0, er});
  endtask

  initial begin
    rst_n = 1'b0;
    instr = itype(6'd3, 5'd0, 5'd0, 16'h1234);
    pc = 32'h100; rs_v = 0; rt_v = 0;
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "reset taken",   {31'd0, taken}, 32'd0);
    chk("R9", "reset next_pc", next_pc, 32'd0);
    chk("R9", "reset link_we", {31'd0, link_we}, 32'd0);
    chk("R9", "reset link_val", link_val, 32'd0);
    rst_n = 1'b1;
    // R9: output does not change before the clock edge
    instr = itype(6'd4, 5'd1, 5'd2, 16'h0010); pc = 32'h2000; rs_v = 7; rt_v = 7;
    #1;
    chk("R9", "pre-edge taken", {31'd0, taken}, 32'd0);
    @(negedge clk);
    chk("R9", "post-edge taken", {31'd0, taken}, 32'd1);
    chk("R9", "post-edge next_pc", next_pc, 32'h2000 + 4 + 32'h40);

    // R2: equal / not-equal over all value pairs, forward and backward offsets
    for (int i = 0; i < 8; i++)
      for (int j = 0; j < 8; j++) begin
        run("R2", itype(6'd4, 5'd3, 5'd4, 16'h0020), 32'h0040_0000 + 32'(i*16), vals[i], vals[j]);
        run("R2", itype(6'd5, 5'd3, 5'd4, 16'hFFF0), 32'h0040_1000, vals[i], vals[j]);
      end
    run("R2", itype(6'd4, 5'd0, 5'd0, 16'h8000), 32'h0000_0010, 0, 0);
    run("R2", itype(6'd5, 5'd0, 5'd0, 16'h7FFF), 32'hFFFF_FFF8, 1, 0);

    // R3: signed compares against zero, rt field ignored
    for (int i = 0; i < 8; i++) begin
      run("R3", itype(6'd6, 5'd5, 5'd0,  16'h0004), 32'h0000_4000, vals[i], 0);
      run("R3", itype(6'd6, 5'd5, 5'd17, 16'h0004), 32'h0000_4000, vals[i], 0);
      run("R3", itype(6'd7, 5'd5, 5'd0,  16'hFFFC), 32'h0000_8000, vals[i], 0);
      run("R3", itype(6'd7, 5'd5, 5'd31, 16'hFFFC), 32'h0000_8000, vals[i], 0);
    end

    // R4 / R7: every selector code of the register-immediate group
    for (int c = 0; c < 32; c++)
      for (int i = 0; i < 8; i++)
        run("R4", itype(6'd1, 5'd6, 5'(c), 16'h0100), 32'h0010_0000, vals[i], 0);

    // R5: region jumps, including a delay slot in the next region
    run("R5", itype(6'd2, 5'd0, 5'd0, 16'h0000) | 32'h03FF_FFFF, 32'h0FFF_FFFC, 0, 0);
    run("R5", itype(6'd3, 5'd0, 5'd0, 16'h0040), 32'h0FFF_FFFC, 0, 0);
    run("R5", itype(6'd2, 5'd0, 5'd0, 16'h1234) | 32'h0155_0000, 32'hA000_0100, 0, 0);
    run("R5", itype(6'd3, 5'd0, 5'd0, 16'h0001), 32'hFFFF_FFF8, 0, 0);

    // R6 / R8 / R7: every function code under opcode 0, aligned and misaligned
    for (int f = 0; f < 64; f++)
      for (int k = 0; k < 4; k++)
        run("R6", rtype(6'(f), 5'd7, 5'(k + 3)), 32'h0000_0200, 32'h0001_0000 + 32'(k), 0);
    run("R8", rtype(6'd9, 5'd2, 5'd0),  32'h0000_0300, 32'h8000_0003, 0);
    run("R8", rtype(6'd8, 5'd2, 5'd0),  32'h0000_0300, 32'h8000_0004, 0);

    // R1: every opcode with neutral operands
    for (int o = 0; o < 64; o++) begin
      run("R1", itype(6'(o), 5'd1, 5'd2, 16'h0008), 32'h0000_1000, 32'h5, 32'h6);
      run("R1", itype(6'(o), 5'd1, 5'd1, 16'hFFFF), 32'h7FFF_FFFC, 32'h0, 32'h0);
    end

    // R7: untaken linking branches still write the link
    run("R7", itype(6'd1, 5'd1, 5'd16, 16'h0010), 32'h0000_5000, 32'h1, 0);
    run("R7", itype(6'd1, 5'd1, 5'd17, 16'h0010), 32'h0000_5000, 32'h8000_0000, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule